// File: doc/BRIEF.md
# Three-Format Instruction Decoder

This block turns one 16-bit machine instruction into the full set of control signals that a single-cycle datapath needs in the same cycle. It is purely combinational. An instruction fetched from program memory goes in, and the decoder drives several outputs. These are the register-file write strobe and its three register selects, the choice between a register and a constant as the second ALU operand, and the ALU function code. They also include the data-memory write strobe and the writeback source choice. For the branch and PC logic it also drives a zero-extended constant, the instruction category, the branch condition code and a 6-bit target offset.

The opcode sits in the upper seven bits. Its top three bits pick a category and its low four bits pick the operation within that category. The nine low bits hold register numbers or constants, and all three formats use the same positions for them. Because of this shared layout, the register selects come straight from fixed bit slices whatever the format. Only the strobes and the selectors depend on the category. The PC sequencing, ALU, register file and memories sit outside this block.

Top module: `instr_decoder_top`

## Requirements
- R1: The destination select is always bits 8:6, source A select bits 5:3 and source B select bits 2:0 of the instruction, in every category.
- R2: The category output equals bits 15:13. Codes: 000 register ALU, 001 immediate ALU, 010 load, 011 store, 100 branch, 101 jump, 110 and 111 no-op.
- R3: The register write strobe is 1 exactly for categories 000, 001 and 010.
- R4: The ALU function equals bits 12:9 for categories 000 and 001, and is the pass-through code 0000 for every other category.
- R5: The constant-operand select is 1 only for category 001. The constant output is bits 2:0 zero-extended to the data width.
- R6: The writeback-from-memory select is 1 only for category 010.
- R7: The memory write strobe is 1 only for category 011.
- R8: The branch flag is 1 only for category 100. The condition output carries bits 12:9 during a branch and is 0000 otherwise.
- R9: The jump flag is 1 only for category 101. The target offset is always bits 8:6 (upper half) joined to bits 2:0 (lower half).
- R10: Categories 110 and 111 write neither the register file nor memory, and raise neither the branch flag nor the jump flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 16 | Instruction word |
| wr_en_o | output | 1 | Register-file write strobe |
| dest_sel_o | output | 3 | Register written on writeback |
| srca_sel_o | output | 3 | Register read on port A |
| srcb_sel_o | output | 3 | Register read on port B |
| use_const_o | output | 1 | 1 selects the constant as the second operand |
| alu_func_o | output | 4 | ALU function code |
| mem_wr_o | output | 1 | Data-memory write strobe |
| wb_mem_o | output | 1 | 1 writes back memory data instead of the ALU result |
| const_o | output | DATA_W | Zero-extended 3-bit constant |
| cat_o | output | 3 | Instruction category |
| cond_o | output | 4 | Branch condition code |
| is_branch_o | output | 1 | Conditional branch present |
| is_jump_o | output | 1 | Unconditional jump present |
| target_off_o | output | 6 | Jump or branch offset field |

## Verification
The assertions check on every input change that each strobe and selector is asserted only in the category that owns it. They check that the branch and jump flags never rise together, that the function code takes either the sub-operation or the pass-through code, and that the constant has no bits above bit 2. Only the bench scenarios can show the values themselves. These include register selects taken from the right bit slices, the exact function and condition codes, the bit order of the offset, and the ignored sub-operation field in load, store, jump and no-op instructions.

// File: rtl/idec_pkg.sv
// Package idec_pkg
// Shared widths, category codes and the control-word type for the
// instruction decoder. Assumes a fixed 16-bit, three-format encoding.
package idec_pkg;

    localparam int INSTR_W = 16;
    localparam int CAT_W   = 3;
    localparam int SUB_W   = 4;
    localparam int REG_W   = 3;
    localparam int OFF_W   = 2 * REG_W;

    localparam logic [SUB_W-1:0] FS_PASS = 4'b0000;

    typedef enum logic [CAT_W-1:0] {
        CAT_REG_ALU = 3'b000,
        CAT_IMM_ALU = 3'b001,
        CAT_LOAD    = 3'b010,
        CAT_STORE   = 3'b011,
        CAT_BRANCH  = 3'b100,
        CAT_JUMP    = 3'b101,
        CAT_NOP6    = 3'b110,
        CAT_NOP7    = 3'b111
    } cat_e;

    // Fields common to all three formats
    typedef struct packed {
        logic [CAT_W-1:0] cat;
        logic [SUB_W-1:0] sub;
        logic [REG_W-1:0] hi;   // destination or upper offset
        logic [REG_W-1:0] mid;  // source A
        logic [REG_W-1:0] lo;   // source B, constant or lower offset
    } fields_t;

    // Per-category strobes and selectors
    typedef struct packed {
        logic wr;
        logic mw;
        logic md;
        logic mb;
        logic alu;
        logic br;
        logic jp;
    } cat_flags_t;

endpackage

// File: rtl/idec_fields.sv
// Module idec_fields
// Cuts the instruction word into its shared fields. Assumes every format
// places the category, sub-operation and three register slots identically.
module idec_fields
    import idec_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output fields_t            fields_o
);

    // Slice the word into named fields
    always_comb begin
        fields_o.cat = instr_i[15:13];
        fields_o.sub = instr_i[12:9];
        fields_o.hi  = instr_i[8:6];
        fields_o.mid = instr_i[5:3];
        fields_o.lo  = instr_i[2:0];
    end

endmodule

// File: rtl/idec_category.sv
// Module idec_category
// Maps the 3-bit category onto the strobes and selectors that differ by
// category. Assumes unused categories are no-ops with all flags low.
module idec_category
    import idec_pkg::*;
(
    input  logic [CAT_W-1:0] cat_i,
    output cat_flags_t       flags_o
);

    // One case per category; default leaves every flag low
    always_comb begin
        flags_o = '0;
        unique case (cat_e'(cat_i))
            CAT_REG_ALU: begin
                flags_o.wr  = 1'b1;
                flags_o.alu = 1'b1;
            end
            CAT_IMM_ALU: begin
                flags_o.wr  = 1'b1;
                flags_o.alu = 1'b1;
                flags_o.mb  = 1'b1;
            end
            CAT_LOAD: begin
                flags_o.wr = 1'b1;
                flags_o.md = 1'b1;
            end
            CAT_STORE:  flags_o.mw = 1'b1;
            CAT_BRANCH: flags_o.br = 1'b1;
            CAT_JUMP:   flags_o.jp = 1'b1;
            CAT_NOP6, CAT_NOP7: flags_o = '0;
            default:    flags_o = '0;
        endcase
    end

endmodule

// File: rtl/idec_const.sv
// Module idec_const
// Builds the zero-extended constant operand and the split offset field.
// Assumes DATA_W is at least the constant width.
module idec_const
    import idec_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  fields_t           fields_i,
    output logic [DATA_W-1:0] const_o,
    output logic [OFF_W-1:0]  off_o
);

    localparam int PAD_W = DATA_W - REG_W;

    // Zero-extend the low slot; width picks the variant
    generate
        if (PAD_W > 0) begin : g_pad
            assign const_o = {{PAD_W{1'b0}}, fields_i.lo};
        end else begin : g_nopad
            assign const_o = fields_i.lo[DATA_W-1:0];
        end
    endgenerate

    // Offset: upper slot above lower slot
    assign off_o = {fields_i.hi, fields_i.lo};

endmodule

// File: rtl/instr_decoder_top.sv
// Module instr_decoder_top
// Combinational decoder from a 16-bit instruction to the datapath control
// word plus branch-side information. Assumes no state; outputs follow the
// input in the same cycle.
module instr_decoder_top
    import idec_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [15:0]       instr_i,
    output logic              wr_en_o,
    output logic [2:0]        dest_sel_o,
    output logic [2:0]        srca_sel_o,
    output logic [2:0]        srcb_sel_o,
    output logic              use_const_o,
    output logic [3:0]        alu_func_o,
    output logic              mem_wr_o,
    output logic              wb_mem_o,
    output logic [DATA_W-1:0] const_o,
    output logic [2:0]        cat_o,
    output logic [3:0]        cond_o,
    output logic              is_branch_o,
    output logic              is_jump_o,
    output logic [5:0]        target_off_o
);

    fields_t    fld;
    cat_flags_t flg;

    idec_fields u_fields (
        .instr_i  (instr_i),
        .fields_o (fld)
    );

    idec_category u_cat (
        .cat_i   (fld.cat),
        .flags_o (flg)
    );

    idec_const #(.DATA_W(DATA_W)) u_const (
        .fields_i (fld),
        .const_o  (const_o),
        .off_o    (target_off_o)
    );

    // Register selects come straight from the fixed slots
    always_comb begin
        dest_sel_o = fld.hi;
        srca_sel_o = fld.mid;
        srcb_sel_o = fld.lo;
        cat_o      = fld.cat;
    end

    // Strobes and selectors from the category flags
    always_comb begin
        wr_en_o     = flg.wr;
        mem_wr_o    = flg.mw;
        wb_mem_o    = flg.md;
        use_const_o = flg.mb;
        is_branch_o = flg.br;
        is_jump_o   = flg.jp;
    end

    // Function code: sub-op for ALU categories, pass-through elsewhere
    always_comb begin
        alu_func_o = flg.alu ? fld.sub : FS_PASS;
        cond_o     = flg.br  ? fld.sub : '0;
    end

    // Category ownership checks on the outputs
    always_comb begin
        assert_wr_cat_R3: assert (!wr_en_o || instr_i[15:13] <= 3'b010)
            else $error("write strobe outside write categories");
        assert_mw_store_R7: assert (!mem_wr_o || instr_i[15:13] == 3'b011)
            else $error("memory write outside store");
        assert_md_load_R6: assert (!wb_mem_o || instr_i[15:13] == 3'b010)
            else $error("memory writeback outside load");
        assert_mb_imm_R5: assert (!use_const_o || instr_i[15:13] == 3'b001)
            else $error("constant select outside immediate");
        assert_fs_code_R4: assert (alu_func_o == FS_PASS || alu_func_o == instr_i[12:9])
            else $error("function code not sub-op or pass");
        assert_flow_excl_R9: assert ($onehot0({is_branch_o, is_jump_o}))
            else $error("branch and jump both set");
        assert_nop_quiet_R10: assert (instr_i[15:14] != 2'b11 ||
                                      !(wr_en_o || mem_wr_o || is_branch_o || is_jump_o))
            else $error("no-op category has side effects");
        assert_const_ext_R5: assert ((const_o >> 3) == '0)
            else $error("constant not zero-extended");
    end

endmodule

// File: tb/instr_decoder_top_tb.sv
module instr_decoder_top_tb;

    localparam int DW = 16;
    localparam int NV = 11;

    logic clk = 1'b0;
    always #2 clk = ~clk;  // 250 MHz

    logic [15:0]   instr;
    logic          wr_en, use_const, mem_wr, wb_mem, is_branch, is_jump;
    logic [2:0]    dest_sel, srca_sel, srcb_sel, cat;
    logic [3:0]    alu_func, cond;
    logic [DW-1:0] cst;
    logic [5:0]    toff;

    instr_decoder_top #(.DATA_W(DW)) u_dut (
        .instr_i(instr), .wr_en_o(wr_en), .dest_sel_o(dest_sel),
        .srca_sel_o(srca_sel), .srcb_sel_o(srcb_sel), .use_const_o(use_const),
        .alu_func_o(alu_func), .mem_wr_o(mem_wr), .wb_mem_o(wb_mem),
        .const_o(cst), .cat_o(cat), .cond_o(cond), .is_branch_o(is_branch),
        .is_jump_o(is_jump), .target_off_o(toff)
    );

    int total = 0;
    int bad   = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected word: wr, da, aa, ba, mb, fs, mw, md, br, jp
    localparam logic [15:0] VIN [NV] = '{
        {3'b000, 4'b0010, 3'd1, 3'd2, 3'd3},
        {3'b000, 4'b1111, 3'd7, 3'd0, 3'd7},
        {3'b001, 4'b0010, 3'd4, 3'd5, 3'd6},
        {3'b001, 4'b1000, 3'd0, 3'd7, 3'd0},
        {3'b010, 4'b0000, 3'd3, 3'd6, 3'd1},
        {3'b010, 4'b1010, 3'd2, 3'd1, 3'd0},
        {3'b011, 4'b0000, 3'd5, 3'd4, 3'd2},
        {3'b100, 4'b0011, 3'd6, 3'd3, 3'd5},
        {3'b101, 4'b0111, 3'd2, 3'd2, 3'd2},
        {3'b110, 4'b1111, 3'd7, 3'd7, 3'd7},
        {3'b111, 4'b0101, 3'd1, 3'd1, 3'd1}
    };
    localparam logic [18:0] VEXP [NV] = '{
        {1'b1, 3'd1, 3'd2, 3'd3, 1'b0, 4'b0010, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b1, 3'd7, 3'd0, 3'd7, 1'b0, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b1, 3'd4, 3'd5, 3'd6, 1'b1, 4'b0010, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b1, 3'd0, 3'd7, 3'd0, 1'b1, 4'b1000, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b1, 3'd3, 3'd6, 3'd1, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0},
        {1'b1, 3'd2, 3'd1, 3'd0, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0},
        {1'b0, 3'd5, 3'd4, 3'd2, 1'b0, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b0, 3'd6, 3'd3, 3'd5, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0},
        {1'b0, 3'd2, 3'd2, 3'd2, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1},
        {1'b0, 3'd7, 3'd7, 3'd7, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b0, 3'd1, 3'd1, 3'd1, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic apply(input logic [15:0] w);
        @(negedge clk);
        instr = w;
        #1;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog
    initial begin
        #(200000 * 4);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        instr = '0;
        repeat (2) @(posedge clk);
        // Initial all-zero word: register ALU, selects 0, pass code
        apply(16'h0000);
        check("R3 zero word wr", {31'd0, wr_en}, 32'd1);
        check("R7 zero word mw", {31'd0, mem_wr}, 32'd0);
        check("R2 zero word cat", {29'd0, cat}, 32'd0);

        // Table walk: R1 R3 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            apply(VIN[i]);
            check("R3 wr",          {31'd0, wr_en},     {31'd0, VEXP[i][18]});
            check("R1 dest",        {29'd0, dest_sel},  {29'd0, VEXP[i][17:15]});
            check("R1 srca",        {29'd0, srca_sel},  {29'd0, VEXP[i][14:12]});
            check("R1 srcb",        {29'd0, srcb_sel},  {29'd0, VEXP[i][11:9]});
            check("R5 mb",          {31'd0, use_const}, {31'd0, VEXP[i][8]});
            check("R4 fs",          {28'd0, alu_func},  {28'd0, VEXP[i][7:4]});
            check("R7 mw",          {31'd0, mem_wr},    {31'd0, VEXP[i][3]});
            check("R6 md",          {31'd0, wb_mem},    {31'd0, VEXP[i][2]});
            check("R8 branch",      {31'd0, is_branch}, {31'd0, VEXP[i][1]});
            check("R9 jump",        {31'd0, is_jump},   {31'd0, VEXP[i][0]});
            check("R2 cat",         {29'd0, cat},       {29'd0, VIN[i][15:13]});
            check("R10 quiet",      {30'd0, (VIN[i][15:14] == 2'b11) && (wr_en || mem_wr), 1'b0}, 32'd0);
        end

        // R5: constant zero-extension at the top value
        apply({3'b001, 4'b0001, 3'd0, 3'd0, 3'd7});
        check("R5 const max", {16'd0, cst}, 32'h0007);
        apply({3'b000, 4'b0001, 3'd7, 3'd7, 3'd0});
        check("R5 const zero", {16'd0, cst}, 32'h0000);

        // R8: condition carried on branch, cleared elsewhere
        apply({3'b100, 4'b1011, 3'd6, 3'd3, 3'd5});
        check("R8 cond branch", {28'd0, cond}, 32'hB);
        check("R9 offset order", {26'd0, toff}, 32'd53);
        apply({3'b000, 4'b1011, 3'd6, 3'd3, 3'd5});
        check("R8 cond non-branch", {28'd0, cond}, 32'h0);

        // R9: offset on jump with asymmetric halves
        apply({3'b101, 4'b0000, 3'd1, 3'd0, 3'd6});
        check("R9 jump offset", {26'd0, toff}, 32'd14);
        check("R4 jump fs pass", {28'd0, alu_func}, 32'd0);

        // R6/R7: store sub-op ignored, no writeback from memory
        apply({3'b011, 4'b1111, 3'd0, 3'd1, 3'd2});
        check("R6 store md", {31'd0, wb_mem}, 32'd0);
        check("R3 store wr", {31'd0, wr_en}, 32'd0);
        check("R4 store fs", {28'd0, alu_func}, 32'd0);

        finish_run();
    end

endmodule